// File: doc/BRIEF.md
# I2C EEPROM Address-Phase Controller

This block is an I2C master sequencer for the addressing phase of a serial EEPROM access. The host supplies a 16-bit word address, a mode bit and a one-cycle start pulse. The block first generates a start condition. It then sends a control byte, followed by one or two address bytes. After each byte it checks the slave acknowledge. When the last byte is acknowledged, the block pulses `done_o` and holds the bus with SCL low. A later phase can then take over the bus.

While the bus is held, the host can request a repeated start or a stop. A missing acknowledge aborts the sequence at once. On an abort the block sets a sticky timeout flag, issues a stop and returns to idle.

SCL and SDA are open-drain. Each output is a drive-low enable. The bit period comes from a runtime divider: every bit is four quarter-phases, and each quarter lasts `div_i`+1 clock cycles. SDA is sampled at the end of the first SCL-high quarter.

Top module: `i2c_addr_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, both lines are released (`scl_oe_o`=0, `sda_oe_o`=0) and `busy_o`, `done_o` and `timeout_o` are 0.
- R2: A `start_i` pulse in idle begins with exactly one start condition (SDA falls while SCL is high) before any data bit is clocked.
- R3: The first byte sent, MSB first, is the control code 1010b in bits 7:4, three select bits in bits 3:1, and a direction bit 0 in bit 0.
- R4: With `dbl_addr_i`=0, the select bits carry A10..A8 and exactly one address byte follows, holding A7..A0. Address bits 15..11 have no effect on the bus.
- R5: With `dbl_addr_i`=1, the select bits are 000, followed by a byte with A15..A8 and then a byte with A7..A0.
- R6: Each byte is followed by a ninth clock on which SDA is released and sampled. A low level is an acknowledge. After the last acknowledge, `done_o` pulses for one cycle with SCL driven low and no stop.
- R7: A high level on any acknowledge clock aborts the sequence: no further byte is clocked, `timeout_o` is set, `done_o` stays 0, a stop condition follows, and the block returns to idle.
- R8: `timeout_o` stays set across later sequences until `clr_timeout_i` is pulsed.
- R9: SDA changes only while SCL is low. The only exceptions are the start edge and the stop edge.
- R10: While the bus is held after `done_o`, `rstart_i` produces a start condition with no stop before it, and the bus is held again. `stop_i` produces a stop condition and a return to idle.
- R11: For every data and acknowledge bit, SCL stays high for exactly 2×(`div_i`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Quarter-phase length minus one, in clock cycles |
| start_i | input | 1 | Begin an addressing sequence (accepted in idle) |
| dbl_addr_i | input | 1 | 1: two address bytes; 0: one address byte with A10..A8 in the select bits |
| addr_i | input | 16 | Word address |
| rstart_i | input | 1 | Issue a repeated start while the bus is held |
| stop_i | input | 1 | Issue a stop while the bus is held |
| clr_timeout_i | input | 1 | Clear the sticky timeout flag |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Drive SCL low when 1 |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| busy_o | output | 1 | A sequence, repeated start or stop is in progress |
| done_o | output | 1 | One-cycle pulse when the address phase completed with all bytes acknowledged |
| timeout_o | output | 1 | Sticky flag set when an acknowledge was missing |

## Verification
The assertions take the inputs on trust in the following ways:
- `div_i` stays constant while a sequence runs.
- The host issues `start_i` only in idle, and `rstart_i` or `stop_i` only while the bus is held.
- `sda_i` is the wired-AND of the block and a slave that changes SDA only while SCL is low.

The bench keeps to these assumptions:
- It drives all host inputs half a cycle away from the active edge.
- It changes the divider only between sequences.
- It waits for `done_o`, or for the end of an abort, before it issues the next command.
- Its slave model pulls SDA low only between the SCL falling edge after the eighth bit and the next falling edge.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned MAX_BYTES = 4;
  localparam logic [3:0]  CTRL_CODE = 4'b1010;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_BIT   = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_SHIFT  = 3'd2,
    S_HOLD   = 3'd3,
    S_STOP   = 3'd4,
    S_RSTART = 3'd5
  } seq_state_e;

  // {scl, sda} levels (1 = released) for a command in a given quarter
  function automatic logic [1:0] line_levels(bus_cmd_e cmd, logic [1:0] qtr, logic tx);
    logic [1:0] lv;
    unique case (cmd)
      CMD_START: lv = (qtr == 2'd0) ? 2'b01 : (qtr == 2'd1) ? 2'b11 :
                      (qtr == 2'd2) ? 2'b10 : 2'b00;
      CMD_STOP:  lv = (qtr == 2'd0) ? 2'b00 : (qtr == 2'd1) ? 2'b10 : 2'b11;
      CMD_BIT:   lv = {(qtr == 2'd1) || (qtr == 2'd2), tx};
      default:   lv = 2'b11;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/i2c_qtr_div.sv
module i2c_qtr_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_addr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     tx_bit_i,
  input  logic     tick_i,
  input  logic     sda_i,
  output logic     active_o,
  output logic     done_o,
  output logic     rx_bit_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);

  logic       active_q, done_q, rx_q, tx_q;
  logic       scl_lvl_q, sda_lvl_q;
  logic [1:0] qtr_q;
  logic [1:0] qtr_nxt;
  bus_cmd_e   cmd_q;

  assign qtr_nxt  = 2'(qtr_q + 2'd1);
  assign active_o = active_q;
  assign done_o   = done_q;
  assign rx_bit_o = rx_q;
  assign scl_oe_o = ~scl_lvl_q;
  assign sda_oe_o = ~sda_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      rx_q      <= 1'b1;
      tx_q      <= 1'b1;
      qtr_q     <= 2'd0;
      cmd_q     <= CMD_NONE;
      scl_lvl_q <= 1'b1;
      sda_lvl_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (cmd_valid_i && cmd_i != CMD_NONE) begin
          active_q <= 1'b1;
          cmd_q    <= cmd_i;
          tx_q     <= tx_bit_i;
          qtr_q    <= 2'd0;
          {scl_lvl_q, sda_lvl_q} <= line_levels(cmd_i, 2'd0, tx_bit_i);
        end
      end else if (tick_i) begin
        // sample at the end of the first SCL-high quarter
        if (qtr_q == 2'd1) rx_q <= sda_i;
        if (qtr_q == 2'd3) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          qtr_q <= qtr_nxt;
          {scl_lvl_q, sda_lvl_q} <= line_levels(cmd_q, qtr_nxt, tx_q);
        end
      end
    end
  end

  p_sda_edge_in_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_q && $past(scl_lvl_q) && (sda_lvl_q != $past(sda_lvl_q)))
      |-> (cmd_q == CMD_START || cmd_q == CMD_STOP));

  p_qtr_waits_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> $stable(qtr_q) && $stable(scl_lvl_q));

endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                start_i,
  input  logic                dbl_addr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rstart_i,
  input  logic                stop_i,
  input  logic                clr_timeout_i,
  input  logic                sda_i,
  output logic                scl_oe_o,
  output logic                sda_oe_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                timeout_o
);

  localparam int unsigned BIDX_W = $clog2(MAX_BYTES);

  seq_state_e        state_q;
  logic              wait_q, done_q, tmo_q, dbl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIDX_W-1:0] byte_idx_q, last_idx;
  logic [3:0]        bit_idx_q;
  logic [7:0]        seq_byte [MAX_BYTES];
  logic [7:0]        cur_byte;

  logic     cmd_valid, tx_bit, tick;
  bus_cmd_e cmd;
  logic     eng_active, eng_done, eng_rx;

  // byte stream of the address phase
  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) seq_byte[i] = '0;
    seq_byte[0] = {CTRL_CODE, (dbl_q ? 3'b000 : addr_q[10:8]), 1'b0};
    seq_byte[1] = dbl_q ? addr_q[15:8] : addr_q[7:0];
    seq_byte[2] = addr_q[7:0];
  end

  assign last_idx = dbl_q ? BIDX_W'(2) : BIDX_W'(1);
  assign cur_byte = seq_byte[byte_idx_q];
  assign tx_bit   = (bit_idx_q < 4'd8) ? cur_byte[3'(~bit_idx_q[2:0])] : 1'b1;

  always_comb begin
    unique case (state_q)
      S_START, S_RSTART: cmd = CMD_START;
      S_SHIFT:           cmd = CMD_BIT;
      S_STOP:            cmd = CMD_STOP;
      default:           cmd = CMD_NONE;
    endcase
  end

  assign cmd_valid = !wait_q && (cmd != CMD_NONE);

  assign busy_o    = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wait_q     <= 1'b0;
      done_q     <= 1'b0;
      tmo_q      <= 1'b0;
      dbl_q      <= 1'b0;
      addr_q     <= '0;
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (clr_timeout_i) tmo_q  <= 1'b0;
      if (cmd_valid)     wait_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          dbl_q   <= dbl_addr_i;
          state_q <= S_START;
        end
        S_HOLD: begin
          if (stop_i)        state_q <= S_STOP;
          else if (rstart_i) state_q <= S_RSTART;
        end
        S_START: if (eng_done) begin
          wait_q     <= 1'b0;
          byte_idx_q <= '0;
          bit_idx_q  <= '0;
          state_q    <= S_SHIFT;
        end
        S_SHIFT: if (eng_done) begin
          wait_q <= 1'b0;
          if (bit_idx_q != 4'd8) begin
            bit_idx_q <= bit_idx_q + 4'd1;
          end else if (eng_rx) begin
            tmo_q   <= 1'b1;
            state_q <= S_STOP;
          end else if (byte_idx_q == last_idx) begin
            done_q  <= 1'b1;
            state_q <= S_HOLD;
          end else begin
            byte_idx_q <= byte_idx_q + 1'b1;
            bit_idx_q  <= '0;
          end
        end
        S_STOP:   if (eng_done) begin wait_q <= 1'b0; state_q <= S_IDLE; end
        S_RSTART: if (eng_done) begin wait_q <= 1'b0; state_q <= S_HOLD; end
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  i2c_qtr_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_active),
    .div_i  (div_i),
    .tick_o (tick)
  );

  i2c_bit_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .tx_bit_i    (tx_bit),
    .tick_i      (tick),
    .sda_i       (sda_i),
    .active_o    (eng_active),
    .done_o      (eng_done),
    .rx_bit_o    (eng_rx),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o)
  );

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !eng_active) |-> (!scl_oe_o && !sda_oe_o && !done_o));

  p_done_holds_scl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scl_oe_o && state_q == S_HOLD && !busy_o));

  p_nack_aborts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SHIFT && eng_done && bit_idx_q == 4'd8 && eng_rx)
      |=> (timeout_o && state_q == S_STOP && !done_o));

  p_timeout_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(timeout_o) && !$past(clr_timeout_i)) |-> timeout_o);

endmodule

// File: tb/i2c_addr_ctrl_test.sv
module i2c_addr_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_r = 8'd1;
  logic        start_r = 1'b0, dbl_r = 1'b0, rstart_r = 1'b0, stop_r = 1'b0, clr_r = 1'b0;
  logic [15:0] addr_r = '0;
  logic        scl_oe, sda_oe, busy, done, tmo;
  logic        slv_drive;
  logic        scl_w, sda_w;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_drive);

  i2c_addr_ctrl #(.DIV_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_r), .start_i(start_r),
    .dbl_addr_i(dbl_r), .addr_i(addr_r), .rstart_i(rstart_r), .stop_i(stop_r),
    .clr_timeout_i(clr_r), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  // bus monitor and slave model
  logic       mon_clr = 1'b0;
  logic [1:0] nack_cfg = 2'd0;
  int         cur_div = 1;
  logic       p_scl, p_sda, in_bit;
  int         starts, stops, nbytes, bitcnt, hi, werr;
  logic [7:0] sh;
  logic [7:0] rxb [4];

  always @(negedge clk) begin
    if (!rst_n || mon_clr) begin
      starts = 0; stops = 0; nbytes = 0; bitcnt = 0; hi = 0; werr = 0;
      in_bit = 1'b0; sh = '0; slv_drive = 1'b0;
      for (int i = 0; i < 4; i++) rxb[i] = '0;
    end else begin
      if (scl_w && p_scl && p_sda && !sda_w) begin
        starts++; bitcnt = 0; in_bit = 1'b0;
      end else if (scl_w && p_scl && !p_sda && sda_w) begin
        stops++; in_bit = 1'b0;
      end
      if (scl_w && !p_scl) begin
        hi = 1; in_bit = 1'b1;
        if (bitcnt < 8) sh = {sh[6:0], sda_w};
        bitcnt++;
        if (bitcnt == 9) begin
          if (nbytes < 4) rxb[nbytes] = sh;
          if (nbytes < 4) nbytes++;
          bitcnt = 0;
        end
      end else if (scl_w) begin
        hi++;
      end
      if (!scl_w && p_scl) begin
        if (in_bit && hi != 2 * (cur_div + 1)) werr++;
        in_bit = 1'b0;
        if (bitcnt == 8) slv_drive = (32'(nack_cfg) != nbytes + 1);
        else if (bitcnt == 0) slv_drive = 1'b0;
      end
    end
    p_scl = scl_w;
    p_sda = sda_w;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic dbl, input logic [15:0] a, input int i);
    if (i == 0) return {4'b1010, (dbl ? 3'b000 : a[10:8]), 1'b0};
    if (dbl && i == 1) return a[15:8];
    return a[7:0];
  endfunction

  logic saw_done;

  task automatic pulse_clr();
    @(negedge clk) clr_r = 1'b1;
    @(negedge clk) clr_r = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, "busy_stuck", busy, 0);
  endtask

  task automatic run_addr(input logic dbl, input logic [15:0] a, input logic [1:0] nk,
                          input int dv, input logic do_stop);
    int n = 0;
    cur_div = dv; div_r = 8'(dv); nack_cfg = nk; dbl_r = dbl; addr_r = a;
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0; start_r = 1'b1;
    @(negedge clk) start_r = 1'b0;
    saw_done = 1'b0;
    while (n < 20000 && !done && !(tmo && !busy)) begin @(negedge clk); n++; end
    if (done) saw_done = 1'b1;
    chk(n < 20000, "sequence_hung", n, 0);
    if (saw_done && do_stop) begin
      @(negedge clk) stop_r = 1'b1;
      @(negedge clk) stop_r = 1'b0;
      wait_idle();
    end
  endtask

  localparam int NVEC = 8;
  // {dbl, addr, nack byte (0 = all acked, k = k-th byte not acked), div}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 2'd0, 4'd1},
    {1'b0, 16'hFD5A, 2'd0, 4'd0},
    {1'b1, 16'h1234, 2'd0, 4'd2},
    {1'b1, 16'hFFFF, 2'd0, 4'd1},
    {1'b0, 16'h07C3, 2'd1, 4'd1},
    {1'b1, 16'hA55A, 2'd2, 4'd0},
    {1'b1, 16'h8001, 2'd3, 4'd1},
    {1'b0, 16'h0300, 2'd2, 4'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !tmo, "R1 flags low in reset", {busy, done, tmo}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !tmo, "R1 idle after reset",
        {scl_oe, sda_oe, busy, tmo}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic        dbl;
      logic [15:0] a;
      logic [1:0]  nk;
      int          dv, nexp, nseen;
      dbl = VEC[v][22]; a = VEC[v][21:6]; nk = VEC[v][5:4]; dv = int'(VEC[v][3:0]);
      pulse_clr();
      run_addr(dbl, a, nk, dv, 1'b1);
      if (tmo) wait_idle();
      nexp  = dbl ? 3 : 2;
      nseen = (nk == 0) ? nexp : int'(nk);
      chk(starts == 1, "R2 one start per sequence", starts, 1);
      chk(nbytes == nseen, "R7 byte count (abort stops at nacked byte)", nbytes, nseen);
      for (int b = 0; b < 4; b++) begin
        if (b < nseen) begin
          logic [7:0] e;
          e = exp_byte(dbl, a, b);
          if (b == 0) chk(rxb[b] == e, "R3 control byte", rxb[b], e);
          else if (dbl) chk(rxb[b] == e, "R5 double address byte", rxb[b], e);
          else chk(rxb[b] == e, "R4 single address byte", rxb[b], e);
        end
      end
      chk(saw_done == (nk == 0), "R6 done pulse", saw_done, nk == 0);
      chk(tmo == (nk != 0), "R7 timeout on missing ack", tmo, nk != 0);
      chk(stops == 1, "R7 R10 one stop ends sequence", stops, 1);
      chk(!scl_oe && !sda_oe, "R1 released after sequence", {scl_oe, sda_oe}, 0);
      chk(werr == 0, "R11 SCL high width", werr, 0);
    end

    // R8: sticky flag survives a later good sequence, cleared by host
    pulse_clr();
    run_addr(1'b0, 16'h0123, 2'd1, 1, 1'b1);
    wait_idle();
    chk(tmo, "R8 timeout set", tmo, 1);
    run_addr(1'b1, 16'h4321, 2'd0, 1, 1'b1);
    chk(saw_done, "R8 good run with flag set", saw_done, 1);
    chk(tmo, "R8 timeout still set", tmo, 1);
    pulse_clr();
    @(negedge clk);
    chk(!tmo, "R8 timeout cleared", tmo, 0);

    // R6 R10: hold, repeated start, then stop
    run_addr(1'b1, 16'hBEEF, 2'd0, 2, 1'b0);
    chk(saw_done, "R6 done before hold", saw_done, 1);
    repeat (20) @(negedge clk);
    chk(scl_oe && !busy, "R6 SCL held low without stop", {scl_oe, busy}, 2);
    chk(stops == 0, "R6 no stop after done", stops, 0);
    @(negedge clk) rstart_r = 1'b1;
    @(negedge clk) rstart_r = 1'b0;
    wait_idle();
    chk(starts == 2 && stops == 0, "R10 repeated start without stop", starts * 16 + stops, 32);
    chk(scl_oe, "R10 bus held after repeated start", scl_oe, 1);
    @(negedge clk) stop_r = 1'b1;
    @(negedge clk) stop_r = 1'b0;
    wait_idle();
    chk(stops == 1, "R10 stop issued", stops, 1);
    chk(!scl_oe && !sda_oe && !busy, "R1 R10 idle after stop", {scl_oe, sda_oe, busy}, 0);
    chk(werr == 0, "R11 SCL high width div2", werr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule